// File: doc/BRIEF.md
# Configuration Record Checker

This block watches the bytes of a configuration record as they arrive from a serial non-volatile memory, one byte per cycle when `byte_valid` is high. It keeps a running 8-bit checksum over the part of the record that the record's own length byte covers, captures the stored checksum byte, and collects an eight-octet unique identifier. When the last byte has been taken, it reports whether the checksum matches, whether the identifier may be used, and whether it is the well-known factory default value. It also returns the identifier, with an old layout repaired.

A second, independent path derives the identifier of a secondary unit. It adds the unit number to a base identifier, lets the carry run through the three low octets only, and flags an error when the carry would leave them. The stream layout uses byte 0 for the length, byte 1 for the stored checksum and bytes 2 to 9 for the identifier. Each position is a parameter.

Top module: `cfgrec_check`

## Requirements
- R1: After a complete record, `csum_ok` is 1 exactly when the bitwise inverse of the 8-bit wrapping sum of all bytes at index below the length value, leaving out index 1, equals the byte at index 1.
- R2: The length value is the byte at index 0. Bytes at index equal to or above it never change `csum_ok`, even when more bytes follow before `rec_last`.
- R3: The identifier is bytes 2 to 9, with byte 2 as octet 0 in bits 63:56. An identifier of all zeros or all ones gives `id_valid` = 0 and `id_out` = 0.
- R4: An identifier equal to 0x0100007511000000 that passes the checksum gives `id_valid` = 1 and `id_warn` = 1. `id_warn` is 0 for any other identifier.
- R5: When octets 0, 1 and 2 are all zero, `id_out` has octet 3 moved to octet 1 and octet 4 moved to octet 2, with octets 0, 3 and 4 cleared and octets 5 to 7 kept. Otherwise `id_out` equals the identifier whenever `id_valid` is 1.
- R6: `rec_done` and all result flags take their values in the cycle after the byte carrying `rec_last` is accepted. They then hold until a byte with `rec_start` and without `rec_last` is accepted, which clears them in the next cycle.
- R7: If the length value is below 10, or fewer bytes than the length value arrive before `rec_last`, then `rec_err` = 1 and `csum_ok`, `id_valid`, `id_warn` and `id_out` are all 0.
- R8: The unit path applies only when `unit_num` ≥ 1, `base_count` > 1 and `unit_num` ≤ `base_count`. Otherwise `unit_ok`, `unit_err` and `unit_id` are 0.
- R9: When the unit path applies, `unit_num` is added to octet 7 (bits 7:0), and a wrap carries into octet 6 and then octet 5. A carry out of octet 5 gives `unit_err` = 1 and `unit_id` = 0. Otherwise `unit_ok` = 1 and `unit_id` is the sum, with octets 0 to 4 unchanged.
- R10: The unit outputs reflect the unit inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A record byte is present this cycle |
| byte_data | input | 8 | Record byte |
| rec_start | input | 1 | Marks the first byte of a record (with byte_valid) |
| rec_last | input | 1 | Marks the final byte of a record (with byte_valid) |
| base_id | input | 64 | Base identifier for unit derivation |
| base_count | input | 8 | Number of identifiers the base unit offers |
| unit_num | input | 8 | Secondary unit number |
| rec_done | output | 1 | Record results are present |
| csum_ok | output | 1 | Checksum matched |
| id_valid | output | 1 | Identifier usable |
| id_warn | output | 1 | Identifier is the factory default |
| rec_err | output | 1 | Record short or length field too small |
| id_out | output | 64 | Repaired identifier, zero when not valid |
| unit_id | output | 64 | Derived unit identifier |
| unit_ok | output | 1 | Derived identifier produced |
| unit_err | output | 1 | Carry left octet 5 |

## Verification
Records of every length from 10 to 24 bytes are sent with several fill patterns. Each is sent with a correct checksum, with one bit of the checksum flipped, and with extra bytes past the stated length. This separates the sum window from the stream length and shows that the checksum byte is left out. Identifiers of all zeros, all ones, the default value and the old layout are sent to tell apart the rejection, warning and repair paths. Short records and records whose length byte is too small exercise the error path. The unit path is swept over every unit number against base identifiers that end in no carry, in a carry into octet 6, in a carry into octet 5, and in a carry out of octet 5, each with several identifier counts. The expected sum is computed in the bench as one 24-bit addition.

// File: rtl/cfgrec_pkg.sv
package cfgrec_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 64;
    localparam logic [ID_W-1:0] FACTORY_ID = 64'h0100_0075_1100_0000;

    typedef struct packed {
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] sum;
        logic [BYTE_W-1:0] csum;
        logic [BYTE_W-1:0] len;
        logic              len_seen;
        logic [ID_W-1:0]   id;
        logic              done;
    } acc_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            ok;
        logic            err;
    } unit_t;
endpackage

// File: rtl/cfgrec_accum.sv
module cfgrec_accum
    import cfgrec_pkg::*;
#(
    parameter int LEN_POS  = 0,
    parameter int CSUM_POS = 1,
    parameter int ID_POS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              rec_start,
    input  logic              rec_last,
    output logic              done_o,
    output logic [BYTE_W-1:0] sum_o,
    output logic [BYTE_W-1:0] csum_o,
    output logic [BYTE_W-1:0] len_o,
    output logic [BYTE_W-1:0] cnt_o,
    output logic [ID_W-1:0]   id_o
);
    localparam int NOCT = ID_W / BYTE_W;
    localparam logic [BYTE_W-1:0] LEN_B  = BYTE_W'(LEN_POS);
    localparam logic [BYTE_W-1:0] CSUM_B = BYTE_W'(CSUM_POS);
    localparam logic [BYTE_W-1:0] ID_B   = BYTE_W'(ID_POS);

    acc_t st_d, st_q, base;
    logic [BYTE_W-1:0] idx;

    always_comb begin
        base = rec_start ? '0 : st_q;
        idx  = rec_start ? '0 : st_q.cnt;
        st_d = st_q;
        if (byte_valid) begin
            st_d = base;
            if (idx != CSUM_B && (!base.len_seen || idx < base.len))
                st_d.sum = base.sum + byte_data;
            if (idx == CSUM_B)
                st_d.csum = byte_data;
            if (idx == LEN_B) begin
                st_d.len      = byte_data;
                st_d.len_seen = 1'b1;
            end
            for (int k = 0; k < NOCT; k++) begin
                if (idx == ID_B + BYTE_W'(k))
                    st_d.id[ID_W-1-BYTE_W*k -: BYTE_W] = byte_data;
            end
            st_d.cnt  = (idx == '1) ? idx : idx + 1'b1;
            st_d.done = rec_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign sum_o  = st_q.sum;
    assign csum_o = st_q.csum;
    assign len_o  = st_q.len;
    assign cnt_o  = st_q.cnt;
    assign id_o   = st_q.id;

    assert_done_follows_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && rec_last) |=> done_o);
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && rec_start && !rec_last) |=> !done_o);
    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(done_o));
endmodule

// File: rtl/cfgrec_idcheck.sv
module cfgrec_idcheck
    import cfgrec_pkg::*;
(
    input  logic [ID_W-1:0] raw_id,
    output logic            is_zero,
    output logic            is_ones,
    output logic            is_factory,
    output logic [ID_W-1:0] fixed_id
);
    logic legacy;

    always_comb begin
        is_zero    = (raw_id == '0);
        is_ones    = (raw_id == '1);
        is_factory = (raw_id == FACTORY_ID);
        legacy     = (raw_id[63:40] == '0);
        fixed_id   = raw_id;
        if (legacy) begin
            fixed_id[55:48] = raw_id[39:32];
            fixed_id[47:40] = raw_id[31:24];
            fixed_id[39:24] = '0;
        end
    end
endmodule

// File: rtl/cfgrec_unitid.sv
module cfgrec_unitid
    import cfgrec_pkg::*;
#(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   base_id,
    input  logic [UNIT_W-1:0] base_count,
    input  logic [UNIT_W-1:0] unit_num,
    output logic [ID_W-1:0]   unit_id,
    output logic              unit_ok,
    output logic              unit_err
);
    unit_t u_d, u_q;
    logic [BYTE_W:0]   s7;
    logic [BYTE_W-1:0] o6, o5;
    logic              c6, c5, applies;

    always_comb begin
        applies = (unit_num != '0) && (base_count > UNIT_W'(1)) && (unit_num <= base_count);
        s7 = {1'b0, base_id[7:0]} + (BYTE_W+1)'(unit_num);
        o6 = base_id[15:8] + BYTE_W'(s7[BYTE_W]);
        c6 = s7[BYTE_W] && (base_id[15:8] == '1);
        o5 = base_id[23:16] + BYTE_W'(c6);
        c5 = c6 && (base_id[23:16] == '1);
        u_d = '0;
        if (applies) begin
            if (c5) begin
                u_d.err = 1'b1;
            end else begin
                u_d.ok = 1'b1;
                u_d.id = {base_id[63:24], o5, o6, s7[BYTE_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign unit_id  = u_q.id;
    assign unit_ok  = u_q.ok;
    assign unit_err = u_q.err;

    assert_err_zeroes_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unit_err |-> (unit_id == '0));
    assert_ok_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unit_ok, unit_err}));
    assert_ok_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unit_ok |-> (unit_id != '0));
    assert_zero_unit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_num == '0) |=> (!unit_ok && !unit_err));
endmodule

// File: rtl/cfgrec_check.sv
module cfgrec_check
    import cfgrec_pkg::*;
#(
    parameter int LEN_POS  = 0,
    parameter int CSUM_POS = 1,
    parameter int ID_POS   = 2,
    parameter int UNIT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              rec_start,
    input  logic              rec_last,
    input  logic [63:0]       base_id,
    input  logic [UNIT_W-1:0] base_count,
    input  logic [UNIT_W-1:0] unit_num,
    output logic              rec_done,
    output logic              csum_ok,
    output logic              id_valid,
    output logic              id_warn,
    output logic              rec_err,
    output logic [63:0]       id_out,
    output logic [63:0]       unit_id,
    output logic              unit_ok,
    output logic              unit_err
);
    localparam int TOP0    = (LEN_POS > CSUM_POS) ? LEN_POS : CSUM_POS;
    localparam int ID_END  = ID_POS + ID_W / BYTE_W - 1;
    localparam int REC_MIN = ((TOP0 > ID_END) ? TOP0 : ID_END) + 1;
    localparam logic [BYTE_W-1:0] MIN_B = BYTE_W'(REC_MIN);

    logic              done;
    logic [BYTE_W-1:0] sum, stored, len, cnt;
    logic [ID_W-1:0]   raw_id, fixed_id;
    logic              is_zero, is_ones, is_factory;
    logic              short_rec, sum_match;

    cfgrec_accum #(.LEN_POS(LEN_POS), .CSUM_POS(CSUM_POS), .ID_POS(ID_POS)) accum_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .rec_start(rec_start), .rec_last(rec_last), .done_o(done), .sum_o(sum),
        .csum_o(stored), .len_o(len), .cnt_o(cnt), .id_o(raw_id)
    );

    cfgrec_idcheck idcheck_i (
        .raw_id(raw_id), .is_zero(is_zero), .is_ones(is_ones),
        .is_factory(is_factory), .fixed_id(fixed_id)
    );

    cfgrec_unitid #(.UNIT_W(UNIT_W)) unitid_i (
        .clk(clk), .rst_n(rst_n), .base_id(base_id), .base_count(base_count),
        .unit_num(unit_num), .unit_id(unit_id), .unit_ok(unit_ok), .unit_err(unit_err)
    );

    always_comb begin
        short_rec = (len < MIN_B) || (cnt < len);
        sum_match = (~sum == stored);
        rec_done  = done;
        rec_err   = done && short_rec;
        csum_ok   = done && !short_rec && sum_match;
        id_valid  = csum_ok && !is_zero && !is_ones;
        id_warn   = csum_ok && is_factory;
        id_out    = id_valid ? fixed_id : '0;
    end

    assert_err_blocks_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_err |-> (!csum_ok && !id_valid && !id_warn && id_out == '0));
    assert_valid_id_usable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (id_out != '0 && id_out != '1));
    assert_warn_implies_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        id_warn |-> id_valid);
    assert_flags_need_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_done |-> (!csum_ok && !rec_err && !id_valid));
endmodule

// File: tb/cfgrec_check_tb_top.sv
module cfgrec_check_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_valid = 1'b0, rec_start = 1'b0, rec_last = 1'b0;
    logic [7:0] byte_data = '0;
    logic [63:0] base_id = '0;
    logic [7:0] base_count = '0, unit_num = '0;
    logic rec_done, csum_ok, id_valid, id_warn, rec_err, unit_ok, unit_err;
    logic [63:0] id_out, unit_id;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] rb [0:31];
    localparam logic [63:0] FACT = 64'h0100_0075_1100_0000;

    always #2 clk = ~clk;

    cfgrec_check dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .rec_start(rec_start), .rec_last(rec_last), .base_id(base_id),
        .base_count(base_count), .unit_num(unit_num), .rec_done(rec_done),
        .csum_ok(csum_ok), .id_valid(id_valid), .id_warn(id_warn), .rec_err(rec_err),
        .id_out(id_out), .unit_id(unit_id), .unit_ok(unit_ok), .unit_err(unit_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] body_sum(input int len);
        logic [7:0] s = '0;
        for (int i = 0; i < len && i < 32; i++)
            if (i != 1) s = s + rb[i];
        return s;
    endfunction

    task automatic fill(input int len, input int seed, input logic [63:0] id);
        rb[0] = 8'(len);
        for (int i = 2; i < 32; i++) rb[i] = 8'(seed * 37 + i * 11 + 5);
        for (int k = 0; k < 8; k++) rb[2 + k] = id[63 - 8 * k -: 8];
        rb[1] = ~body_sum(len);
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_data = rb[i];
            rec_start = (i == 0); rec_last = (i == n - 1);
        end
        @(negedge clk);
        byte_valid = 1'b0; rec_start = 1'b0; rec_last = 1'b0;
    endtask

    task automatic check_rec(input int n, input string tag);
        int len;
        logic err, ok, val, warn;
        logic [63:0] raw, fixd;
        len  = int'(rb[0]);
        err  = (len < 10) || (n < len);
        ok   = !err && (~body_sum(len) == rb[1]);
        for (int k = 0; k < 8; k++) raw[63 - 8 * k -: 8] = rb[2 + k];
        val  = ok && raw != '0 && raw != '1;
        warn = ok && raw == FACT;
        fixd = (raw[63:40] == '0) ? {8'h00, raw[39:32], raw[31:24], 16'h0000, raw[23:0]} : raw;
        chk({tag, " R6 rec_done"}, 64'(rec_done), 64'(1));
        chk({tag, " R7 rec_err"}, 64'(rec_err), 64'(err));
        chk({tag, " R1 csum_ok"}, 64'(csum_ok), 64'(ok));
        chk({tag, " R3 id_valid"}, 64'(id_valid), 64'(val));
        chk({tag, " R4 id_warn"}, 64'(id_warn), 64'(warn));
        chk({tag, " R5 id_out"}, id_out, val ? fixd : 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset rec_done", 64'(rec_done), 64'(0));
        chk("R6 reset id_out", id_out, 64'h0);
        chk("R8 reset unit_ok", 64'(unit_ok), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: lengths, patterns, flipped checksum, trailing bytes
        for (int len = 10; len <= 24; len++) begin
            for (int seed = 0; seed < 4; seed++) begin
                fill(len, seed, 64'h1234_5678_9ABC_DE00 + 64'(len * 4 + seed));
                send(len);
                check_rec(len, "good");
                rb[1] = rb[1] ^ 8'(1 << seed);
                send(len);
                check_rec(len, "R1 flip");
                rb[1] = rb[1] ^ 8'(1 << seed);
                send(len + 6);
                check_rec(len + 6, "R2 trailing");
            end
        end

        // R3 R4 R5 identifier classes
        fill(12, 1, 64'h0);                    send(12); check_rec(12, "R3 zero");
        fill(12, 2, '1);                       send(12); check_rec(12, "R3 ones");
        fill(14, 3, FACT);                     send(14); check_rec(14, "R4 factory");
        chk("R4 warn set", 64'(id_warn), 64'(1));
        fill(16, 4, 64'h0000_00AB_CD12_3456);  send(16); check_rec(16, "R5 legacy");
        chk("R5 legacy value", id_out, 64'h00AB_CD00_0012_3456);
        fill(16, 5, 64'h0000_0100_0000_0000);  send(16); check_rec(16, "R5 near-legacy");

        // R7 short record and small length field
        fill(20, 6, 64'h0102_0304_0506_0708);  send(15); check_rec(15, "R7 short");
        chk("R7 short err", 64'(rec_err), 64'(1));
        fill(9, 7, 64'h0102_0304_0506_0708);   send(12); check_rec(12, "R7 smalllen");
        chk("R7 smalllen err", 64'(rec_err), 64'(1));

        // R6 hold and clear
        fill(12, 8, 64'h0A0B_0C0D_0E0F_1011);  send(12);
        repeat (3) @(negedge clk);
        check_rec(12, "R6 hold");
        byte_valid = 1'b1; byte_data = rb[0]; rec_start = 1'b1; rec_last = 1'b0;
        @(negedge clk);
        byte_valid = 1'b0; rec_start = 1'b0;
        chk("R6 clear rec_done", 64'(rec_done), 64'(0));
        chk("R6 clear csum_ok", 64'(csum_ok), 64'(0));
        send(12); check_rec(12, "R6 restart");

        // R8 R9 R10 unit derivation sweep
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 4; c++) begin
                logic [63:0] bid;
                logic [7:0]  cnt;
                bid = (b == 0) ? 64'h1122_3344_5566_7788 :
                      (b == 1) ? 64'hAABB_CCDD_EE00_FFF0 :
                      (b == 2) ? 64'h0102_0304_0500_FFFE :
                                 64'hAABB_CCDD_EEFF_FFF0;
                cnt = (c == 0) ? 8'd0 : (c == 1) ? 8'd1 : (c == 2) ? 8'd2 : 8'd255;
                for (int t = 0; t < 256; t++) begin
                    logic app;
                    logic [24:0] s;
                    base_id = bid; base_count = cnt; unit_num = 8'(t);
                    @(negedge clk);
                    app = (t != 0) && (cnt > 8'd1) && (8'(t) <= cnt);
                    s = {1'b0, bid[23:0]} + 25'(t);
                    chk("R8 R10 unit_ok", 64'(unit_ok), 64'(app && !s[24]));
                    chk("R9 unit_err", 64'(unit_err), 64'(app && s[24]));
                    chk("R9 unit_id", unit_id,
                        (app && !s[24]) ? {bid[63:24], s[23:0]} : 64'h0);
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule